// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block drives an 8-bit successive-approximation converter from the digital side. A software write that sets the start bit arms a conversion. The start is lined up with the next Q4 phase strobe of the instruction cycle. When the RC conversion clock is selected, the block also waits one extra instruction cycle, which gives a following sleep instruction time to execute. From that point the hold switch stays open. A half-period timer derived from the system clock paces a trial register that settles one bit per conversion clock period, from the top bit down, using the comparator's verdict on the current DAC code.

After 9.5 conversion clock periods the result register takes the settled code. In the same clock edge the start bit clears and the done flag rises. Until that edge the previous result stays readable. The input is sampled again only after a recovery interval of 1.5 conversion clock periods. Writing zero to the start bit while a conversion is pending or running abandons it. The analog hold circuit, the comparator and the DAC are outside the block.

Top module: `sar_seq_top`

## Requirements
- R1: After reset, sample_en is 1, go_bit is 0, done_flag is 0, result is 0 and dac_code is 0.
- R2: With clk_rc=0, a write of go_wdata=1 while idle sets go_bit. The conversion starts on the first clock edge at which q4_stb is sampled high after that write. From that edge sample_en is 0.
- R3: With clk_rc=1, the conversion starts INSTR_CLKS (default 4) clock edges after the edge at which q4_stb is sampled high. sample_en stays 1 during that wait.
- R4: sample_en is 0 from the start of a conversion until the end of its recovery interval.
- R5: The conversion begins with dac_code=0x80. At each conversion clock edge (every second half-period tick), bit k is kept if cmp_ge=1 (input >= DAC) and cleared otherwise, and bit k-1 is set. Bits are resolved from 7 down to 0.
- R6: One conversion clock period lasts 2, 8 or 32 system clocks for div_sel = 0, 1 and 2 or 3, and 6 clocks when clk_rc=1. A conversion lasts 19 half-periods (9.5 periods) counted from its start edge.
- R7: result keeps its previous value during a conversion. On the completion edge it takes the settled code, go_bit falls and done_flag is set.
- R8: sample_en returns to 1 three half-periods (1.5 periods) after the completion edge.
- R9: A write of go_wdata=0 while armed, waiting or converting returns the block to idle on that edge. sample_en becomes 1, result is unchanged and done_flag is not set.
- R10: flag_clr=1 clears done_flag. A completion in the same cycle takes priority.
- R11: A write of 1 during a conversion has no effect. A write of 1 during recovery sets go_bit, and a new conversion is armed once recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go_wr | input | 1 | Write strobe for the start bit |
| go_wdata | input | 1 | Value written to the start bit |
| flag_clr | input | 1 | Clears done_flag |
| clk_rc | input | 1 | 1 selects the RC conversion clock |
| div_sel | input | 2 | Oscillator divide select: 0 for /2, 1 for /8, 2 or 3 for /32 |
| q4_stb | input | 1 | Q4 phase strobe of the instruction cycle |
| cmp_ge | input | 1 | Comparator: input >= DAC output |
| sample_en | output | 1 | Closes the hold switch (sampling) |
| go_bit | output | 1 | Start bit readback (busy) |
| dac_code | output | 8 | Trial code to the DAC |
| result | output | 8 | Conversion result register |
| done_flag | output | 1 | Conversion-complete interrupt flag |

## Verification
The bench targets the start alignment to q4_stb, with and without the RC wait. A design that ignores the strobe or skips the wait starts early, and sample_en falls on the wrong cycle. Conversions run with every divide ratio and with codes 0x00, 0xFF and mixed patterns. An off-by-one in the half-period count moves the completion edge, and a bit-order error shows up as wrong intermediate DAC codes. The bench also aborts a running conversion and re-arms during recovery. A design that loads the result on abort, raises the flag, or drops the queued start is reported on the cycle it diverges.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARM   = 3'd1,
        ST_RCW   = 3'd2,
        ST_CONV  = 3'd3,
        ST_RECOV = 3'd4
    } seq_st_e;
endpackage

// File: rtl/sar_tad_timer.sv
module sar_tad_timer #(
    parameter int CW   = 5,
    parameter int HW   = 5,
    parameter int MAXH = 19
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic [CW-1:0] hp,
    output logic          tick,
    output logic [HW-1:0] half
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [HW-1:0] half;
    } tmr_t;

    tmr_t r_q, r_d;

    assign tick = run && (r_q.cnt == hp - CW'(1));
    assign half = r_q.half;

    always_comb begin
        r_d = r_q;
        if (clr) begin
            r_d.cnt  = '0;
            r_d.half = '0;
        end else if (run) begin
            if (tick) begin
                r_d.cnt  = '0;
                r_d.half = r_q.half + HW'(1);
            end else begin
                r_d.cnt = r_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R6
    half_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.half <= HW'(MAXH));
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
    parameter int W  = 8,
    parameter int IW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          upd,
    input  logic [IW-1:0] idx,
    input  logic          cmp,
    output logic [W-1:0]  code
);
    logic [W-1:0] code_q, code_d;

    assign code = code_q;

    always_comb begin
        code_d = code_q;
        if (load) begin
            code_d        = '0;
            code_d[W-1]   = 1'b1;
        end else if (upd) begin
            code_d[idx] = cmp;
            if (idx != '0) code_d[idx - IW'(1)] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= code_d;
    end

    // R5
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (code_q == {1'b1, {(W-1){1'b0}}}));
endmodule

// File: rtl/sar_seq_top.sv
module sar_seq_top import sar_seq_pkg::*; #(
    parameter int W          = 8,
    parameter int HP_DIV2    = 1,
    parameter int HP_DIV8    = 4,
    parameter int HP_DIV32   = 16,
    parameter int HP_RC      = 3,
    parameter int INSTR_CLKS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_wr,
    input  logic         go_wdata,
    input  logic         flag_clr,
    input  logic         clk_rc,
    input  logic [1:0]   div_sel,
    input  logic         q4_stb,
    input  logic         cmp_ge,
    output logic         sample_en,
    output logic         go_bit,
    output logic [W-1:0] dac_code,
    output logic [W-1:0] result,
    output logic         done_flag
);
    localparam int MAXH  = 2 * W + 3;
    localparam int RECH  = 3;
    localparam int HW    = $clog2(MAXH + 1);
    localparam int HPA   = (HP_DIV2 > HP_DIV8) ? HP_DIV2 : HP_DIV8;
    localparam int HPB   = (HP_DIV32 > HP_RC) ? HP_DIV32 : HP_RC;
    localparam int HPMAX = (HPA > HPB) ? HPA : HPB;
    localparam int CW    = $clog2(HPMAX + 1);
    localparam int RW    = $clog2(INSTR_CLKS + 1);
    localparam int IW    = (W > 1) ? $clog2(W) : 1;

    typedef struct packed {
        seq_st_e       st;
        logic          go;
        logic [RW-1:0] rcw;
        logic [W-1:0]  res;
        logic          flag;
    } regs_t;

    regs_t r_q, r_d;

    logic          tick, clr, run, load, upd, go_next, set_flag;
    logic [HW-1:0] half, hn;
    logic [IW-1:0] idx;
    logic [CW-1:0] hp;
    logic [W-1:0]  code;

    always_comb begin
        if (clk_rc) hp = CW'(HP_RC);
        else begin
            case (div_sel)
                2'd0:    hp = CW'(HP_DIV2);
                2'd1:    hp = CW'(HP_DIV8);
                default: hp = CW'(HP_DIV32);
            endcase
        end
    end

    assign run = (r_q.st == ST_CONV) || (r_q.st == ST_RECOV);
    assign hn  = half + HW'(1);

    sar_tad_timer #(.CW(CW), .HW(HW), .MAXH(MAXH)) tmr_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .hp(hp),
        .tick(tick), .half(half)
    );

    sar_trial_reg #(.W(W), .IW(IW)) trial_i (
        .clk(clk), .rst_n(rst_n), .load(load), .upd(upd), .idx(idx),
        .cmp(cmp_ge), .code(code)
    );

    always_comb begin
        r_d      = r_q;
        clr      = 1'b0;
        load     = 1'b0;
        upd      = 1'b0;
        idx      = '0;
        set_flag = 1'b0;
        go_next  = go_wr ? go_wdata : r_q.go;
        r_d.go   = go_next;
        case (r_q.st)
            ST_IDLE: if (go_next) r_d.st = ST_ARM;
            ST_ARM: begin
                if (!go_next) r_d.st = ST_IDLE;
                else if (q4_stb) begin
                    if (clk_rc) begin
                        r_d.st  = ST_RCW;
                        r_d.rcw = '0;
                    end else begin
                        r_d.st = ST_CONV;
                        clr    = 1'b1;
                        load   = 1'b1;
                    end
                end
            end
            ST_RCW: begin
                if (!go_next) r_d.st = ST_IDLE;
                else if (r_q.rcw == RW'(INSTR_CLKS - 1)) begin
                    r_d.st = ST_CONV;
                    clr    = 1'b1;
                    load   = 1'b1;
                end else r_d.rcw = r_q.rcw + RW'(1);
            end
            ST_CONV: begin
                if (!go_next) r_d.st = ST_IDLE;
                else if (tick) begin
                    if (hn == HW'(MAXH)) begin
                        r_d.st   = ST_RECOV;
                        r_d.res  = code;
                        r_d.go   = 1'b0;
                        set_flag = 1'b1;
                        clr      = 1'b1;
                    end else if (!hn[0] && hn <= HW'(2 * W)) begin
                        upd = 1'b1;
                        idx = IW'(W - int'(hn >> 1));
                    end
                end
            end
            ST_RECOV: if (tick && hn == HW'(RECH)) r_d.st = ST_IDLE;
            default:  r_d.st = ST_IDLE;
        endcase
        r_d.flag = set_flag ? 1'b1 : (flag_clr ? 1'b0 : r_q.flag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sample_en = (r_q.st == ST_IDLE) || (r_q.st == ST_ARM) || (r_q.st == ST_RCW);
    assign go_bit    = r_q.go;
    assign dac_code  = code;
    assign result    = r_q.res;
    assign done_flag = r_q.flag;

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> $fell(go_bit));
    // R7
    flag_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(go_bit));
    // R8
    recov_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(go_bit) && !$past(go_wr)) |-> !sample_en);
    // R9
    abort_noflag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_wr && !go_wdata && r_q.st == ST_CONV) |=> !$rose(done_flag));
endmodule

// File: tb/sar_seq_top_tb_top.sv
module sar_seq_top_tb_top;
    localparam int INSTR = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       go_wr = 1'b0, go_wdata = 1'b0, flag_clr = 1'b0, clk_rc = 1'b0, q4_stb = 1'b0;
    logic [1:0] div_sel = 2'd0;
    logic       cmp_ge;
    logic       sample_en, go_bit, done_flag;
    logic [7:0] dac_code, result;
    int         vin = 0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    string scen = "R1";

    // reference model state
    int m_mode = 0, m_k = 0, m_res = 0;
    bit m_go = 0, m_flag = 0;

    always #10 clk = ~clk;

    assign cmp_ge = (vin >= int'(dac_code));

    sar_seq_top dut_i (
        .clk(clk), .rst_n(rst_n), .go_wr(go_wr), .go_wdata(go_wdata),
        .flag_clr(flag_clr), .clk_rc(clk_rc), .div_sel(div_sel), .q4_stb(q4_stb),
        .cmp_ge(cmp_ge), .sample_en(sample_en), .go_bit(go_bit),
        .dac_code(dac_code), .result(result), .done_flag(done_flag)
    );

    function automatic int half_clks();
        if (clk_rc) return 3;
        case (div_sel)
            2'd0:    return 1;
            2'd1:    return 4;
            default: return 16;
        endcase
    endfunction

    task automatic chk(string tag, string sig, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (scenario %s) %s act=%0d exp=%0d", tag, scen, sig, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;
    always @(negedge clk) q4_stb <= (cyc % 4 == 2);

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        bit gn, done;
        int hp;
        gn   = go_wr ? go_wdata : m_go;
        done = 0;
        hp   = half_clks();
        if (!rst_n) begin
            m_mode <= 0; m_k <= 0; m_res <= 0; m_go <= 0; m_flag <= 0;
        end else begin
            case (m_mode)
                0: begin m_go <= gn; if (gn) m_mode <= 1; end
                1: if (!gn) begin m_go <= 0; m_mode <= 0; end
                   else begin
                       m_go <= 1;
                       if (q4_stb) begin m_mode <= clk_rc ? 2 : 3; m_k <= 0; end
                   end
                2: if (!gn) begin m_go <= 0; m_mode <= 0; end
                   else begin
                       m_go <= 1;
                       if (m_k + 1 == INSTR) begin m_mode <= 3; m_k <= 0; end
                       else m_k <= m_k + 1;
                   end
                3: if (!gn) begin m_go <= 0; m_mode <= 0; end
                   else if (m_k + 1 == 19 * hp) begin
                       m_mode <= 4; m_k <= 0; m_res <= vin; m_go <= 0; done = 1;
                   end else begin m_k <= m_k + 1; m_go <= 1; end
                default: begin
                    m_go <= gn;
                    if (m_k + 1 == 3 * hp) begin m_mode <= 0; m_k <= 0; end
                    else m_k <= m_k + 1;
                end
            endcase
            if (done) m_flag <= 1;
            else if (flag_clr) m_flag <= 0;
        end
    end

    // compare every cycle, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4", "sample_en", sample_en, (m_mode <= 2) ? 1 : 0);
            chk("R7", "go_bit", go_bit, m_go);
            chk("R7", "done_flag", done_flag, m_flag);
            chk("R7", "result", result, m_res);
            if (m_mode == 3) begin
                int j, e;
                j = (m_k / half_clks()) / 2;
                if (j > 8) j = 8;
                if (j == 8) e = vin;
                else e = (vin & ((8'hFF << (8 - j)) & 8'hFF)) | (1 << (7 - j));
                chk("R5", "dac_code", dac_code, e);
            end
        end
    end

    task automatic wr_go(bit v);
        @(negedge clk); go_wr = 1'b1; go_wdata = v;
        @(negedge clk); go_wr = 1'b0; go_wdata = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin @(negedge clk); n++; end while (!(m_mode == 0 && !m_go) && n < 5000);
    endtask

    task automatic run_conv(string tag, bit rc, logic [1:0] ds, int v);
        scen = tag;
        @(negedge clk); clk_rc = rc; div_sel = ds; vin = v;
        wr_go(1'b1);
        wait_idle();
        chk(tag, "final result", result, v);
        chk(tag, "done flag", done_flag, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset sample_en", sample_en, 1);
        chk("R1", "reset go_bit", go_bit, 0);
        chk("R1", "reset done_flag", done_flag, 0);
        chk("R1", "reset result", result, 0);
        chk("R1", "reset dac_code", dac_code, 0);

        run_conv("R2", 1'b0, 2'd0, 8'hA5);
        run_conv("R6", 1'b0, 2'd1, 8'h00);
        run_conv("R6", 1'b0, 2'd2, 8'hFF);

        scen = "R10";
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        chk("R10", "flag after clear", done_flag, 0);

        run_conv("R3", 1'b1, 2'd0, 8'h3C);
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;

        scen = "R9";
        clk_rc = 1'b0; div_sel = 2'd1; vin = 8'h11;
        wr_go(1'b1);
        repeat (40) @(negedge clk);
        wr_go(1'b0);
        chk("R9", "sample after abort", sample_en, 1);
        chk("R9", "result after abort", result, 8'h3C);
        repeat (20) @(negedge clk);
        chk("R9", "flag after abort", done_flag, 0);

        scen = "R11";
        div_sel = 2'd0; vin = 8'h5A;
        wr_go(1'b1);
        repeat (10) @(negedge clk);
        wr_go(1'b1);
        begin
            int n = 0;
            while (m_mode != 4 && n < 1000) begin @(negedge clk); n++; end
        end
        wr_go(1'b1);
        chk("R11", "go during recovery", go_bit, 1);
        wait_idle();
        chk("R11", "second result", result, 8'h5A);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(150000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule